// File: doc/BRIEF.md
# Bit-Serial Adder with Stored Carry

This block adds two binary words that are presented one bit per clock, least significant bit first. A single full-adder cell combines the two operand bits with the carry left over from the previous bit position. The new sum bit is captured in a register, and the new carry is captured in a second register that feeds the adder on the next clock. In this way an N-bit word passes through in N clocks on a one-bit datapath.

A synchronous clear marks the start of each word. It empties both the sum register and the carry register, so the lowest bit of every word is added with a carry-in of zero. A separate output-enable input gates the registered sum onto the output pin. While the enable is low the output reads zero, but the adder keeps running. After the last bit of a word, the stored carry is the carry-out of the whole word.

Top module: `serial_adder`

## Requirements
- R1: On a clock edge where `clr` is 1, both the stored sum and the stored carry become 0. After that edge `sum_o` and `carry_o` read 0.
- R2: On a clock edge where `clr` is 0, the stored sum takes `a_i XOR b_i XOR carry_o`, using the values present just before the edge. It therefore appears at the output exactly one clock after the operand bits.
- R3: On a clock edge where `clr` is 0, `carry_o` takes the majority of `a_i`, `b_i` and the previous `carry_o`.
- R4: The carry stored at one bit position is the carry-in for the next bit. Feeding an N-bit word LSB first after a clear gives the bits of (A+B) mod 2^N on `sum_o`, one per clock, LSB first. After the last bit, `carry_o` equals bit N of A+B.
- R5: While `en_i` is 0, `sum_o` is 0. Adding continues underneath, so the carry state and later sum bits are unaffected.
- R6: While `en_i` is 1, `sum_o` shows the stored sum bit.
- R7: When `clr` is 1 in the same cycle as operand bits that would generate a carry, the clear wins and neither the sum nor the carry is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear of the sum and carry registers, active high |
| a_i | input | 1 | Operand A bit, LSB first |
| b_i | input | 1 | Operand B bit, LSB first |
| en_i | input | 1 | Output enable: 1 lets the stored sum reach `sum_o` |
| sum_o | output | 1 | Gated registered sum bit |
| carry_o | output | 1 | Stored carry, which is the carry-out of the word after its last bit |

## Verification
Two events can fall in the same cycle: the clear, and operand bits that would set the carry. The bench first loads a carry of 1. It then raises `clr` while presenting `a_i=b_i=1`, and requires both `sum_o` and `carry_o` to read 0 after that edge. A second overlap is between output gating and carry propagation. Words are added with the enable held low for some bits, and the bench then checks that the bits shown once the enable returns, and the final carry, still match the arithmetic sum.

// File: rtl/serial_adder.sv
module serial_adder (
  input  logic clk,
  input  logic clr,
  input  logic a_i,
  input  logic b_i,
  input  logic en_i,
  output logic sum_o,
  output logic carry_o
);
  logic sum_q;
  logic cy_q;
  logic fa_sum;
  logic fa_cy;

  assign fa_sum = a_i ^ b_i ^ cy_q;
  assign fa_cy  = (a_i & b_i) | (a_i & cy_q) | (b_i & cy_q);

  always_ff @(posedge clk) begin
    if (clr) begin
      sum_q <= 1'b0;
      cy_q  <= 1'b0;
    end else begin
      sum_q <= fa_sum;
      cy_q  <= fa_cy;
    end
  end

  assign sum_o   = en_i & sum_q;
  assign carry_o = cy_q;
endmodule

module serial_adder_chk (
  input logic clk,
  input logic clr,
  input logic a_i,
  input logic b_i,
  input logic en_i,
  input logic sum_o,
  input logic carry_o,
  input logic sum_q
);
  assert_clear_R1: assert property (@(posedge clk) clr |=> (!sum_q && !carry_o));

  assert_sum_R2: assert property (@(posedge clk) disable iff (clr)
    !clr ##1 !clr |-> sum_q == ($past(a_i) ^ $past(b_i) ^ $past(carry_o)));

  assert_carry_R3: assert property (@(posedge clk) disable iff (clr)
    !clr ##1 !clr |-> carry_o == (($past(a_i) & $past(b_i)) |
                                  ($past(a_i) & $past(carry_o)) |
                                  ($past(b_i) & $past(carry_o))));

  assert_gate_off_R5: assert property (@(posedge clk) !en_i |-> !sum_o);

  assert_gate_on_R6: assert property (@(posedge clk) disable iff (clr)
    en_i && !$past(clr) |-> sum_o == ($past(a_i) ^ $past(b_i) ^ $past(carry_o)));
endmodule

bind serial_adder serial_adder_chk u_chk (
  .clk(clk), .clr(clr), .a_i(a_i), .b_i(b_i), .en_i(en_i),
  .sum_o(sum_o), .carry_o(carry_o), .sum_q(sum_q)
);

// File: tb/serial_adder_test.sv
module serial_adder_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic a_i = 1'b0;
  logic b_i = 1'b0;
  logic en_i = 1'b1;
  logic sum_o;
  logic carry_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_adder uut (
    .clk(clk), .clr(clr), .a_i(a_i), .b_i(b_i), .en_i(en_i),
    .sum_o(sum_o), .carry_o(carry_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clock_in(input logic c, input logic a, input logic b, input logic g);
    @(negedge clk);
    clr = c; a_i = a; b_i = b; en_i = g;
    @(posedge clk);
    #1;
  endtask

  task automatic test_reset();
    clock_in(1'b1, 1'b1, 1'b1, 1'b1);
    check("R1 sum", sum_o, 1'b0);
    check("R1 carry", carry_o, 1'b0);
  endtask

  task automatic test_single_bits();
    logic cy;
    for (int p = 0; p < 8; p++) begin
      clock_in(1'b1, 1'b0, 1'b0, 1'b1);
      cy = 1'b0;
      if (p[2]) begin
        clock_in(1'b0, 1'b1, 1'b1, 1'b1);
        cy = 1'b1;
      end
      clock_in(1'b0, p[0], p[1], 1'b1);
      check("R2", sum_o, p[0] ^ p[1] ^ cy);
      check("R3", carry_o, (p[0] & p[1]) | (p[0] & cy) | (p[1] & cy));
    end
  endtask

  task automatic add_word(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] en_mask);
    logic [W:0] ref_sum;
    ref_sum = {1'b0, a} + {1'b0, b};
    clock_in(1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < W; i++) begin
      clock_in(1'b0, a[i], b[i], en_mask[i]);
      if (en_mask[i]) check("R4 R6 word bit", sum_o, ref_sum[i]);
      else check("R5 gated bit", sum_o, 1'b0);
    end
    check("R4 carry out", carry_o, ref_sum[W]);
  endtask

  task automatic test_clear_collision();
    clock_in(1'b1, 1'b0, 1'b0, 1'b1);
    clock_in(1'b0, 1'b1, 1'b1, 1'b1);
    check("R3 setup", carry_o, 1'b1);
    clock_in(1'b1, 1'b1, 1'b1, 1'b1);
    check("R7 sum", sum_o, 1'b0);
    check("R7 carry", carry_o, 1'b0);
    clock_in(1'b0, 1'b1, 1'b0, 1'b1);
    check("R7 next bit sees zero carry", sum_o, 1'b1);
  endtask

  task automatic test_gate_toggle();
    clock_in(1'b1, 1'b0, 1'b0, 1'b1);
    clock_in(1'b0, 1'b1, 1'b0, 1'b0);
    check("R5 off", sum_o, 1'b0);
    @(negedge clk);
    en_i = 1'b1;
    #1;
    check("R6 on", sum_o, 1'b1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    test_reset();
    test_single_bits();
    add_word(8'h00, 8'h00, 8'hFF);
    add_word(8'hFF, 8'h01, 8'hFF);
    add_word(8'hA5, 8'h5A, 8'hFF);
    add_word(8'h7F, 8'h7F, 8'hFF);
    add_word(8'hC3, 8'h9E, 8'h0F);
    add_word(8'hFF, 8'hFF, 8'hF0);
    add_word(8'h3C, 8'h0F, 8'h00);
    test_clear_collision();
    test_gate_toggle();
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule